// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This block sits between three asynchronous interrupt request pins and a processor core. Each pin is first brought into the core clock domain, and a rising edge on it sets a sticky pending flag. Level does not matter, and more edges on a flag that is already set add nothing. The block keeps one request line to the core. That line is high when any flag is set and the global enable is on.

When several flags are set, a fixed priority picks the lowest-numbered source. The block then presents that source's number, together with the program-memory location that holds the start address of its service routine. Source 0 maps to the top word of a 4K program space, and each higher-numbered source maps to the word just below the previous one.

Once the core has taken the request, it pulses an acknowledge. That clears only the presented source's flag, and the next pending source then moves up.

Top module: `irq_vector_unit`

## Requirements
- R1: While reset is asserted and directly after it, `pendFlags` is all zeros, `irqReq` is 0, `srcId` is 0 and `vecAddr` is 0.
- R2: A 0-to-1 change on `irqIn[i]`, driven between clock edges, sets `pendFlags[i]` after the third following rising clock edge and not before. An input held high sets the flag only once.
- R3: A set pending flag stays set, whatever its input does, until its source is acknowledged.
- R4: `irqReq` is 1 exactly when `globalEn` is 1 and at least one pending flag is set. `pendFlags` shows the flags whatever the enable is.
- R5: When several flags are set, `srcId` gives the lowest-numbered pending source (source 0 highest, source 2 lowest).
- R6: `vecAddr` is 0x0FFF for source 0, 0x0FFE for source 1 and 0x0FFD for source 2, that is 0x0FFF minus `srcId`. It is 0 when no flag is set.
- R7: `ackIn` sampled high while `irqReq` is high clears only the flag of the presented source and keeps all others. `ackIn` while `irqReq` is low changes nothing.
- R8: Further rising edges on a source whose flag is already set merge into the one request, so a single acknowledge clears it.
- R9: If a new rising edge of a source is detected in the same cycle as an acknowledge of that source, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 3 | Asynchronous interrupt request lines, bit i is source i |
| globalEn | input | 1 | Global interrupt enable |
| ackIn | input | 1 | Acknowledge of the presented source, one cycle per request |
| irqReq | output | 1 | Request to the core |
| srcId | output | 2 | Number of the presented source |
| vecAddr | output | 16 | Program-memory location of the presented source's routine address |
| pendFlags | output | 3 | Per-source pending flags |

## Verification
The bench uses the default parameters: three sources, a two-stage synchronizer, a 16-bit address and a vector top of 0x0FFF. With these values every source and every vector location can be reached. The fixed three-cycle edge latency also lets the bench line up an acknowledge exactly on the cycle a fresh edge is detected. Simultaneous edges, staggered edges, repeated pulses and enable gating are each driven by their own scenario.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int IRQ_N   = 3;
  parameter int IRQ_IDW = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;

  typedef struct packed {
    logic [IRQ_N-1:0]   clrMask;
    logic               selValid;
    logic [IRQ_IDW-1:0] selIdx;
  } irqStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IRQ_N-1:0]  irqIn,
  input  irqStrobe_t        strobe,
  output logic [IRQ_N-1:0]  pend,
  output logic [ADDR_W-1:0] vecAddr
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [IRQ_N-1:0] synced;
  logic [IRQ_N-1:0] prevQ;
  logic [IRQ_N-1:0] edgeHit;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], irqIn[i]};
    end
    assign synced[i] = chain[LAST];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevQ[i] <= 1'b0;
      else       prevQ[i] <= synced[i];
    end
    assign edgeHit[i] = synced[i] & ~prevQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           pend[i] <= 1'b0;
      else if (edgeHit[i]) pend[i] <= 1'b1;
      else if (strobe.clrMask[i]) pend[i] <= 1'b0;
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(synced[i]) |=> pend[i]); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (pend[i] && !strobe.clrMask[i]) |=> pend[i]); // R3
  end

  always_comb begin
    if (strobe.selValid) vecAddr = VEC_TOP - ADDR_W'(strobe.selIdx);
    else                 vecAddr = '0;
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_N-1:0] pend,
  input  logic             globalEn,
  input  logic             ackIn,
  output irqStrobe_t       strobe,
  output logic             irqReq
);
  logic [IRQ_IDW-1:0] winIdx;
  logic               anyPend;

  always_comb begin
    winIdx  = '0;
    anyPend = 1'b0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        winIdx  = IRQ_IDW'(i);
        anyPend = 1'b1;
      end
    end
  end

  assign irqReq = anyPend & globalEn;

  always_comb begin
    strobe.selIdx   = winIdx;
    strobe.selValid = anyPend;
    strobe.clrMask  = '0;
    if (irqReq && ackIn) strobe.clrMask[winIdx] = 1'b1;
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.clrMask)); // R7
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    pend[0] |-> (strobe.selIdx == '0)); // R5
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn || !ackIn) |-> (strobe.clrMask == '0)); // R7
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h0FFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IRQ_N-1:0]   irqIn,
  input  logic               globalEn,
  input  logic               ackIn,
  output logic               irqReq,
  output logic [IRQ_IDW-1:0] srcId,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [IRQ_N-1:0]   pendFlags
);
  irqStrobe_t strobe;

  irq_control u_ctrl (
    .clk(clk), .rstN(rstN), .pend(pendFlags), .globalEn(globalEn),
    .ackIn(ackIn), .strobe(strobe), .irqReq(irqReq)
  );

  irq_datapath #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .VEC_TOP(VEC_TOP)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe),
    .pend(pendFlags), .vecAddr(vecAddr)
  );

  assign srcId = strobe.selIdx;

  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendFlags != '0)); // R4
  AST_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && ackIn && !$past(irqReq)) |-> pendFlags[srcId]); // R7
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  irqIn;
  logic        globalEn;
  logic        ackIn;
  logic        irqReq;
  logic [1:0]  srcId;
  logic [15:0] vecAddr;
  logic [2:0]  pendFlags;

  int total = 0;
  int bad   = 0;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .globalEn(globalEn), .ackIn(ackIn),
    .irqReq(irqReq), .srcId(srcId), .vecAddr(vecAddr), .pendFlags(pendFlags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack1();
    ackIn = 1'b1; tick(1); ackIn = 1'b0;
  endtask

  task automatic cleanup();
    irqIn = '0; globalEn = 1'b1; tick(4);
    for (int k = 0; k < 4; k++) if (irqReq) ack1();
  endtask

  task automatic t_reset();
    chk("R1 pend", pendFlags, 0); chk("R1 req", irqReq, 0);
    chk("R1 src", srcId, 0);      chk("R1 vec", vecAddr, 0);
  endtask

  task automatic t_single();
    irqIn[1] = 1'b1; tick(2);
    chk("R2 early", pendFlags, 3'b000);
    tick(1);
    chk("R2 set", pendFlags, 3'b010); chk("R4 req", irqReq, 1);
    chk("R5 src", srcId, 1);          chk("R6 vec1", vecAddr, 16'h0FFE);
    ack1();
    chk("R7 clr", pendFlags, 3'b000);
    tick(5);
    chk("R2 level", pendFlags, 3'b000);
    cleanup();
  endtask

  task automatic t_simul();
    irqIn = 3'b111; tick(3);
    chk("R5 all", pendFlags, 3'b111); chk("R5 src0", srcId, 0);
    chk("R6 vec0", vecAddr, 16'h0FFF);
    ack1();
    chk("R7 keep", pendFlags, 3'b110); chk("R6 vec1b", vecAddr, 16'h0FFE);
    ack1();
    chk("R7 keep2", pendFlags, 3'b100); chk("R6 vec2", vecAddr, 16'h0FFD);
    chk("R5 src2", srcId, 2);
    ack1();
    chk("R7 empty", pendFlags, 3'b000); chk("R6 none", vecAddr, 0);
    cleanup();
  endtask

  task automatic t_overlap();
    irqIn[2] = 1'b1; tick(1);
    irqIn[0] = 1'b1; tick(2);
    chk("R5 first", pendFlags, 3'b100); chk("R5 src2o", srcId, 2);
    tick(1);
    chk("R5 preempt", pendFlags, 3'b101); chk("R5 src0o", srcId, 0);
    cleanup();
  endtask

  task automatic t_enable();
    globalEn = 1'b0; irqIn[1] = 1'b1; tick(3);
    chk("R4 gated", irqReq, 0); chk("R4 flags", pendFlags, 3'b010);
    ack1();
    chk("R7 ign", pendFlags, 3'b010);
    globalEn = 1'b1; tick(1);
    chk("R4 open", irqReq, 1);
    cleanup();
  endtask

  task automatic t_sticky();
    irqIn[2] = 1'b1; tick(2); irqIn[2] = 1'b0; tick(10);
    chk("R3 hold", pendFlags, 3'b100);
    cleanup();
  endtask

  task automatic t_merge();
    irqIn[1] = 1'b1; tick(3); irqIn[1] = 1'b0; tick(3);
    irqIn[1] = 1'b1; tick(3); irqIn[1] = 1'b0; tick(3);
    chk("R8 one", pendFlags, 3'b010);
    ack1();
    chk("R8 gone", pendFlags, 3'b000);
    cleanup();
  endtask

  task automatic t_collide();
    irqIn[0] = 1'b1; tick(3); irqIn[0] = 1'b0; tick(4);
    chk("R9 pre", pendFlags, 3'b001);
    irqIn[0] = 1'b1; tick(2);
    ack1();
    chk("R9 keep", pendFlags, 3'b001);
    ack1();
    chk("R9 clr", pendFlags, 3'b000);
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = '0; globalEn = 1'b1; ackIn = 1'b0;
    tick(3);
    t_reset();
    rstN = 1'b1; tick(1);
    t_reset();
    t_single();
    t_simul();
    t_overlap();
    t_enable();
    t_sticky();
    t_merge();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule